// File: doc/BRIEF.md
# Floppy Controller Bus Glue

This block sits between a processor bus that runs each transfer inside one phase of an E clock and uses a single read/write line, and a floppy disk controller chip that expects separate active-low read and write strobes. The block splits the read/write line into the two strobes. Because the controller needs write data held well past the end of its write strobe, the block also drives the controller's data inputs from a register that keeps the last written byte after E falls.

The same block runs the drive mechanics. Any cycle addressed to the controller starts the spindle motor, or keeps it running, through a retriggerable timeout. When the motor starts from rest, a settle delay must pass before the head is reported loaded. A separate drive register, written from the data bus, picks one of several drives through a one-hot select. All timers count cycles of the fast system clock `clk`, and their lengths are parameters. The bus inputs (E, read/write, selects, data) are taken to be synchronous to `clk`.

Top module: `fdc_bus_glue`

## Requirements
- R1: `fdc_re_n` is low exactly while `fdc_sel` is high, `e_clk` is high and `rw` is 1 (read). This holds for the whole E-high time.
- R2: `fdc_we_n` is low exactly while `fdc_sel` is high, `e_clk` is high and `rw` is 0 (write). The two strobes are never low together.
- R3: `fdc_wdata` takes the value of `din` seen on the last clock edge of a controller write's E-high time. After E falls it holds that value, through any later bus activity that is not a controller write.
- R4: the clock edge on which `fdc_sel & e_clk` is first seen high marks a controller access. That access turns `motor_on` on, or keeps it on, and reloads the motor timeout. `motor_on` drops exactly MOTOR_TICKS clock edges after the most recent access.
- R5: when an access starts the motor from rest, `head_ready` stays low for HEAD_TICKS clock edges and then goes high. An access while the motor is already running does not restart this delay.
- R6: `head_ready` is low whenever `motor_on` is low.
- R7: a write to the drive register (`drvreg_sel`, `e_clk` high, `rw` = 0) stores `din` as a drive number. Drive number n asserts only `drive_en[n]`. A stored number of NDRIVES or more asserts no select.
- R8: after reset, both strobes are high, `fdc_wdata` is 0, `motor_on` and `head_ready` are low, and `drive_en` is all zero until the first drive-register write.
- R9: drive-register cycles assert neither controller strobe and do not start the motor. Reads of the drive register and controller writes leave `drive_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than E |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_clk | input | 1 | Bus E phase; transfers happen while high |
| rw | input | 1 | Bus direction, 1 = read, 0 = write |
| fdc_sel | input | 1 | Decoded select of the controller chip |
| drvreg_sel | input | 1 | Decoded select of the drive register |
| din | input | DW | Processor data bus |
| fdc_re_n | output | 1 | Controller read strobe, active low |
| fdc_we_n | output | 1 | Controller write strobe, active low |
| fdc_wdata | output | DW | Held write data to the controller |
| motor_on | output | 1 | Spindle motor enable |
| head_ready | output | 1 | Head-load settle delay has elapsed |
| drive_en | output | NDRIVES | One-hot drive select |

## Verification
Several rules are checked by assertions on every cycle. The strobes are mutually exclusive and gated by E and the direction line. The held write data changes only after a controller write phase. The motor can start only from a controller access. Head-ready implies the motor is on and never rises in the same cycle the motor starts. The drive select is at most one-hot. The exact timeout and settle lengths, retriggering during a run, out-of-range drive numbers, and the absence of side effects from drive-register and read cycles appear only in the bench's scenarios. There, a reference timer model and queued expectations are compared against the outputs.

// File: rtl/fdc_bus_glue.sv
module fdc_bus_glue #(
  parameter int DW          = 8,
  parameter int NDRIVES     = 4,
  parameter int MOTOR_TICKS = 20_000_000,
  parameter int HEAD_TICKS  = 160_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               e_clk,
  input  logic               rw,
  input  logic               fdc_sel,
  input  logic               drvreg_sel,
  input  logic [DW-1:0]      din,
  output logic               fdc_re_n,
  output logic               fdc_we_n,
  output logic [DW-1:0]      fdc_wdata,
  output logic               motor_on,
  output logic               head_ready,
  output logic [NDRIVES-1:0] drive_en
);
  localparam int MCW = $clog2(MOTOR_TICKS + 1);
  localparam int HCW = $clog2(HEAD_TICKS + 1);
  localparam logic [MCW-1:0] MOT_LOAD  = MCW'(MOTOR_TICKS);
  localparam logic [HCW-1:0] HEAD_LOAD = HCW'(HEAD_TICKS);

  logic           fdc_cyc, fdc_cyc_q, fdc_start, drv_wr;
  logic [MCW-1:0] mot_cnt;
  logic [HCW-1:0] head_cnt;
  logic [DW-1:0]  drv_num;
  logic           drv_valid;

  assign fdc_cyc   = e_clk & fdc_sel;
  assign fdc_start = fdc_cyc & ~fdc_cyc_q;
  assign drv_wr    = e_clk & drvreg_sel & ~rw;

  assign fdc_re_n  = ~(fdc_cyc & rw);
  assign fdc_we_n  = ~(fdc_cyc & ~rw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdc_cyc_q <= 1'b0;
      fdc_wdata <= '0;
    end else begin
      fdc_cyc_q <= fdc_cyc;
      if (fdc_cyc && !rw) fdc_wdata <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mot_cnt  <= '0;
      head_cnt <= '0;
    end else begin
      if (fdc_start)             mot_cnt <= MOT_LOAD;
      else if (mot_cnt != '0)    mot_cnt <= mot_cnt - 1'b1;
      if (fdc_start && mot_cnt == '0) head_cnt <= HEAD_LOAD;
      else if (head_cnt != '0)        head_cnt <= head_cnt - 1'b1;
    end
  end

  assign motor_on   = (mot_cnt != '0);
  assign head_ready = motor_on & (head_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_num   <= '0;
      drv_valid <= 1'b0;
    end else if (drv_wr) begin
      drv_num   <= din;
      drv_valid <= 1'b1;
    end
  end

  for (genvar i = 0; i < NDRIVES; i++) begin : g_dsel
    assign drive_en[i] = drv_valid && (drv_num == DW'(i));
  end
endmodule

// File: rtl/fdc_bus_glue_chk.sv
module fdc_bus_glue_chk #(
  parameter int DW      = 8,
  parameter int NDRIVES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               e_clk,
  input logic               rw,
  input logic               fdc_sel,
  input logic               fdc_re_n,
  input logic               fdc_we_n,
  input logic [DW-1:0]      fdc_wdata,
  input logic               motor_on,
  input logic               head_ready,
  input logic [NDRIVES-1:0] drive_en
);
  // R1
  re_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_re_n |-> (e_clk && rw && fdc_sel));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fdc_re_n && !fdc_we_n));
  // R3
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(e_clk && fdc_sel && !rw) |-> $stable(fdc_wdata));
  // R4
  motor_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_on) |-> $past(e_clk && fdc_sel));
  // R5
  head_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(head_ready) |-> $past(motor_on));
  // R6
  head_motor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_ready |-> motor_on);
  // R7
  drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_en));
endmodule

bind fdc_bus_glue fdc_bus_glue_chk #(.DW(DW), .NDRIVES(NDRIVES)) u_chk (
  .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .rw(rw), .fdc_sel(fdc_sel),
  .fdc_re_n(fdc_re_n), .fdc_we_n(fdc_we_n), .fdc_wdata(fdc_wdata),
  .motor_on(motor_on), .head_ready(head_ready), .drive_en(drive_en));

// File: tb/fdc_bus_glue_bench.sv
module fdc_bus_glue_bench;
  localparam int MT = 60;
  localparam int HT = 20;

  logic clk = 0, rst_n = 0, e_clk = 0, rw = 1, fdc_sel = 0, drvreg_sel = 0;
  logic [7:0] din = 0;
  logic fdc_re_n, fdc_we_n, motor_on, head_ready;
  logic [7:0] fdc_wdata;
  logic [3:0] drive_en;

  fdc_bus_glue #(.DW(8), .NDRIVES(4), .MOTOR_TICKS(MT), .HEAD_TICKS(HT)) u_fdc_bus_glue (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .rw(rw), .fdc_sel(fdc_sel),
    .drvreg_sel(drvreg_sel), .din(din), .fdc_re_n(fdc_re_n), .fdc_we_n(fdc_we_n),
    .fdc_wdata(fdc_wdata), .motor_on(motor_on), .head_ready(head_ready),
    .drive_en(drive_en));

  always #2 clk = ~clk;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_drv = 4'b0000;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // reference timer model, from R4/R5/R6
  int edge_n = 0, last_acc = 0, start_e = 0;
  bit have = 0, m_on = 0, m_rdy = 0, sel_q = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      have = 0; m_on = 0; m_rdy = 0; sel_q = 0;
    end else begin
      edge_n++;
      if (e_clk && fdc_sel && !sel_q) begin
        if (!m_on) start_e = edge_n;
        last_acc = edge_n;
        have = 1;
      end
      sel_q = e_clk && fdc_sel;
      m_on  = have && (edge_n - last_acc < MT);
      m_rdy = m_on && (edge_n - start_e >= HT);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 motor_on", {7'd0, motor_on}, {7'd0, m_on});
      chk(m_on ? "R5 head_ready" : "R6 head_ready", {7'd0, head_ready}, {7'd0, m_rdy});
    end
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      case (it.kind)
        0: chk(it.tag, {7'd0, fdc_re_n}, it.exp);
        1: chk(it.tag, {7'd0, fdc_we_n}, it.exp);
        2: chk(it.tag, fdc_wdata, it.exp);
        default: chk(it.tag, {4'd0, drive_en}, it.exp);
      endcase
    end
  end

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step;
  endtask

  task automatic cyc(bit f, bit d, bit r, logic [7:0] dat);
    step; fdc_sel = f; drvreg_sel = d; rw = r; din = dat; e_clk = 0;
    step; e_clk = 1;
    push(0, (f && r) ? 8'd0 : 8'd1, "R1 re_n E-high");
    push(1, (f && !r) ? 8'd0 : 8'd1, d ? "R9 we_n drvreg" : "R2 we_n E-high");
    step; step; step;
    push(0, (f && r) ? 8'd0 : 8'd1, "R1 re_n late");
    push(1, (f && !r) ? 8'd0 : 8'd1, "R2 we_n late");
    step; e_clk = 0;
    push(0, 8'd1, "R1 re_n E-low"); push(1, 8'd1, "R2 we_n E-low");
    step; din = ~dat; fdc_sel = 0; drvreg_sel = 0; rw = 1;
    step;
    if (d && !r) exp_drv = (dat < 4) ? 4'(1 << dat) : 4'b0000;
    push(3, {4'd0, exp_drv}, d ? "R7 drive_en" : "R9 drive_en kept");
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    step;
    push(0, 8'd1, "R8 re_n"); push(1, 8'd1, "R8 we_n");
    push(2, 8'h00, "R8 wdata"); push(3, 8'h00, "R8 drive_en");
    cyc(1, 0, 1, 8'h11);
    cyc(1, 0, 0, 8'hA5);
    push(2, 8'hA5, "R3 wdata held");
    cyc(1, 0, 1, 8'h77);
    push(2, 8'hA5, "R3 wdata kept on read");
    cyc(0, 1, 0, 8'd2);
    cyc(0, 1, 0, 8'd5);
    cyc(0, 1, 0, 8'd3);
    cyc(0, 1, 1, 8'd0);
    cyc(1, 0, 0, 8'h3C);
    push(2, 8'h3C, "R3 wdata new");
    push(2, 8'h3C, "R3 wdata second look");
    idle(MT + 10);
    cyc(1, 0, 1, 8'h00);
    idle(30);
    cyc(1, 0, 1, 8'h00);
    idle(MT + 10);
    cyc(0, 1, 0, 8'd1);
    idle(20);
    cyc(1, 0, 0, 8'h5A);
    idle(5);
    push(2, 8'h5A, "R3 wdata final");
    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule